// File: doc/BRIEF.md
# Minute Alarm Comparator

This block keeps a 24-bit alarm time and compares it against the running calendar value once per minute. The comparison does not run continuously. A pulse marking the minute boundary starts a delay counter, and the counter advances on a 32.768 kHz tick enable. When the 131st tick arrives, the block compares the alarm time with the calendar value present at that moment. If the two match, a sticky match flag is set.

The flag holds its value until the host clears it with a command. It drives an output pin directly. A date-ignore mode limits the comparison to the minute and hour fields, so the alarm repeats every day. The host turns this mode on and off with two separate commands. The host loads the alarm time with a single write strobe.

Both the calendar value and the alarm value use one field layout:
- minutes in bits [6:0]
- hours in bits [12:7]
- day in bits [18:13]
- month in bits [23:19]

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset, `comp_o` and `noda_o` are both 0.
- R2: After a `min_fall` pulse, the comparison happens in the cycle of the 131st `tick_en` pulse. If all 24 bits of `cal_value` equal the alarm register in that cycle, `comp_o` is 1 from the next cycle on.
- R3: Before the 131st tick after a minute edge, `comp_o` does not change. When the comparison finds a mismatch, `comp_o` keeps its previous value.
- R4: When `noda_o` is 1, only bits [12:0] (minutes and hours) take part in the comparison. A difference in bits [23:13] still gives a match.
- R5: When `noda_o` is 0, a difference in any bit of [23:13] prevents the match.
- R6: Once set, `comp_o` stays 1 until `cmd_clr_comp` is pulsed. It is then 0 in the next cycle, even when the clear comes in the cycle right after the set.
- R7: If `cmd_clr_comp` arrives in the same cycle as a successful comparison, `comp_o` is 1 afterwards. The set wins.
- R8: `cmd_set_noda` makes `noda_o` 1 in the next cycle, and `cmd_clr_noda` alone makes it 0. If both arrive together, `noda_o` becomes 1. When neither command is given, `noda_o` holds its value.
- R9: A value written with `alarm_we` is the one used by every later comparison.
- R10: `tick_en` pulses that arrive with no preceding minute edge, or after the evaluation for that edge has been done, never set `comp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| min_fall | input | 1 | One-cycle pulse at the minute boundary |
| cal_value | input | 24 | Current calendar value: month, day, hour, minute |
| alarm_we | input | 1 | Write strobe for the alarm register |
| alarm_wdata | input | 24 | New alarm value, same layout as `cal_value` |
| cmd_clr_comp | input | 1 | Clears the match flag |
| cmd_set_noda | input | 1 | Turns on date-ignore mode |
| cmd_clr_noda | input | 1 | Turns off date-ignore mode |
| comp_o | output | 1 | Sticky match flag, also used as the output pin |
| noda_o | output | 1 | Date-ignore mode readback |

## Verification
A wrong delay count moves the rising edge of `comp_o` away from the tick that carries the 131st pulse. That error appears within a single minute evaluation, about 524 clock cycles of the bench. A corrupted alarm register, a wrong field mask, or a stuck mode flag gives a wrong `comp_o` value at the end of the first affected evaluation. A broken latch or a broken clear priority shows on `comp_o` one cycle after the clear command.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int MIN_W      = 7;
  localparam int HR_W       = 6;
  localparam int DAY_W      = 6;
  localparam int MON_W      = 5;
  localparam int CAL_W      = MIN_W + HR_W + DAY_W + MON_W;
  localparam int NUM_FIELDS = 4;
  // fields below this index remain compared in date-ignore mode
  localparam int TIME_ONLY_FIELDS = 2;

  function automatic int fld_w(input int idx);
    case (idx)
      0:       return MIN_W;
      1:       return HR_W;
      2:       return DAY_W;
      default: return MON_W;
    endcase
  endfunction

  function automatic int fld_lsb(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      if (k < idx) acc += fld_w(k);
    end
    return acc;
  endfunction
endpackage

// File: rtl/alarm_delay.sv
module alarm_delay #(
  parameter int DELAY_TICKS = 131
) (
  input  logic clk,
  input  logic rst_n,
  input  logic min_edge,
  input  logic tick_en,
  output logic fire
);
  localparam int CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_tick;

  assign last_tick = armed_q && tick_en && (cnt_q == LAST);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (min_edge) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && tick_en) begin
      if (last_tick) begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fire = last_tick && !min_edge;
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_cmp_pkg::*;
(
  input  logic [CAL_W-1:0] cal,
  input  logic [CAL_W-1:0] alarm,
  input  logic             time_only,
  output logic             match
);
  logic [NUM_FIELDS-1:0] feq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int LSB = fld_lsb(i);
    localparam int W   = fld_w(i);
    assign feq[i] = (cal[LSB +: W] == alarm[LSB +: W]);
  end

  assign match = time_only ? (&feq[TIME_ONLY_FIELDS-1:0]) : (&feq);
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_comp,
  input  logic set_noda,
  input  logic clr_noda,
  output logic comp,
  output logic noda
);
  logic comp_d, noda_d;

  always_comb begin
    comp_d = comp;
    if (clr_comp) comp_d = 1'b0;
    if (hit)      comp_d = 1'b1;
    noda_d = noda;
    if (clr_noda) noda_d = 1'b0;
    if (set_noda) noda_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp <= 1'b0;
      noda <= 1'b0;
    end else begin
      comp <= comp_d;
      noda <= noda_d;
    end
  end
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_cmp_pkg::*;
#(
  parameter int DELAY_TICKS = 131
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             min_fall,
  input  logic [CAL_W-1:0] cal_value,
  input  logic             alarm_we,
  input  logic [CAL_W-1:0] alarm_wdata,
  input  logic             cmd_clr_comp,
  input  logic             cmd_set_noda,
  input  logic             cmd_clr_noda,
  output logic             comp_o,
  output logic             noda_o
);
  logic [1:0]       rst_sync;
  logic             core_rst_n;
  logic [CAL_W-1:0] alarm_q, alarm_d;
  logic             fire, match, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  always_comb begin
    alarm_d = alarm_q;
    if (alarm_we) alarm_d = alarm_wdata;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) alarm_q <= '0;
    else             alarm_q <= alarm_d;
  end

  alarm_delay #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .min_edge (min_fall),
    .tick_en  (tick_en),
    .fire     (fire)
  );

  alarm_match u_match (
    .cal       (cal_value),
    .alarm     (alarm_q),
    .time_only (noda_o),
    .match     (match)
  );

  assign hit = fire && match;

  alarm_flags u_flags (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .hit      (hit),
    .clr_comp (cmd_clr_comp),
    .set_noda (cmd_set_noda),
    .clr_noda (cmd_clr_noda),
    .comp     (comp_o),
    .noda     (noda_o)
  );
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk #(
  parameter int DELAY_TICKS = 131
) (
  input logic clk,
  input logic core_rst_n,
  input logic tick_en,
  input logic min_fall,
  input logic fire,
  input logic match,
  input logic cmd_clr_comp,
  input logic cmd_set_noda,
  input logic cmd_clr_noda,
  input logic comp_o,
  input logic noda_o
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  logic          m_armed;
  logic [CW-1:0] m_cnt;
  logic          m_due;

  assign m_due = m_armed && tick_en && (m_cnt == CW'(DELAY_TICKS - 1)) && !min_fall;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      m_armed <= 1'b0;
      m_cnt   <= '0;
    end else if (min_fall) begin
      m_armed <= 1'b1;
      m_cnt   <= '0;
    end else if (m_armed && tick_en) begin
      if (m_cnt == CW'(DELAY_TICKS - 1)) m_armed <= 1'b0;
      else                               m_cnt   <= m_cnt + 1'b1;
    end
  end

  // R2, R10: the comparison fires exactly on the final delay tick
  p_fire_timing_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    fire == m_due);

  // R3: comp only rises after a fired match
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(comp_o) |-> $past(fire && match));

  // R6: held without a clear
  p_latched_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (comp_o && !cmd_clr_comp) |=> comp_o);

  // R6: clear takes effect next cycle
  p_clear_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cmd_clr_comp && !(fire && match)) |=> !comp_o);

  // R7: set wins
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (fire && match) |=> comp_o);

  // R8: mode commands
  p_noda_set_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    cmd_set_noda |=> noda_o);
  p_noda_clr_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cmd_clr_noda && !cmd_set_noda) |=> !noda_o);
  p_noda_hold_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!cmd_clr_noda && !cmd_set_noda) |=> $stable(noda_o));
endmodule

bind alarm_cmp_top alarm_cmp_chk #(.DELAY_TICKS(DELAY_TICKS)) u_chk (
  .clk          (clk),
  .core_rst_n   (core_rst_n),
  .tick_en      (tick_en),
  .min_fall     (min_fall),
  .fire         (fire),
  .match        (match),
  .cmd_clr_comp (cmd_clr_comp),
  .cmd_set_noda (cmd_set_noda),
  .cmd_clr_noda (cmd_clr_noda),
  .comp_o       (comp_o),
  .noda_o       (noda_o)
);

// File: tb/tb_alarm_cmp_top.sv
module tb_alarm_cmp_top;
  localparam int TICKS = 131;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, min_fall = 1'b0;
  logic [23:0] cal_value = '0;
  logic        alarm_we = 1'b0;
  logic [23:0] alarm_wdata = '0;
  logic        cmd_clr_comp = 1'b0, cmd_set_noda = 1'b0, cmd_clr_noda = 1'b0;
  logic        comp_o, noda_o;

  int total = 0, bad = 0;
  logic [23:0] m_alarm;
  logic        m_noda, m_comp;

  always #10 clk = ~clk;

  alarm_cmp_top dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .min_fall(min_fall),
    .cal_value(cal_value), .alarm_we(alarm_we), .alarm_wdata(alarm_wdata),
    .cmd_clr_comp(cmd_clr_comp), .cmd_set_noda(cmd_set_noda),
    .cmd_clr_noda(cmd_clr_noda), .comp_o(comp_o), .noda_o(noda_o)
  );

  function automatic logic exp_match(input logic [23:0] c, input logic [23:0] a,
                                     input logic nd);
    if (nd) return c[12:0] == a[12:0];
    return c == a;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic write_alarm(input logic [23:0] v);
    @(negedge clk); alarm_we = 1'b1; alarm_wdata = v;
    @(negedge clk); alarm_we = 1'b0;
    m_alarm = v;
  endtask

  task automatic pulse_clr();
    @(negedge clk); cmd_clr_comp = 1'b1;
    @(negedge clk); cmd_clr_comp = 1'b0;
    m_comp = 1'b0;
  endtask

  task automatic set_noda(input logic v);
    @(negedge clk); cmd_set_noda = v; cmd_clr_noda = !v;
    @(negedge clk); cmd_set_noda = 1'b0; cmd_clr_noda = 1'b0;
    m_noda = v;
  endtask

  // one minute evaluation; calendar held at cal through the delay
  task automatic run_minute(input logic [23:0] cal, input logic clr_last, input string req);
    @(negedge clk); cal_value = cal; min_fall = 1'b1;
    @(negedge clk); min_fall = 1'b0;
    for (int k = 0; k < TICKS; k++) begin
      tick_en = 1'b1;
      if (k == TICKS - 1) begin
        check("R3", comp_o, m_comp);
        cmd_clr_comp = clr_last;
      end
      @(negedge clk); tick_en = 1'b0; cmd_clr_comp = 1'b0;
      repeat (3) @(negedge clk);
    end
    if (exp_match(cal, m_alarm, m_noda)) m_comp = 1'b1;
    else if (clr_last) m_comp = 1'b0;
    check(req, comp_o, m_comp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] a, c;
    void'($urandom(32'd20240611));
    m_alarm = '0; m_noda = 1'b0; m_comp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 comp", comp_o, 1'b0);
    check("R1 noda", noda_o, 1'b0);

    // R2: full match sets at the final tick
    a = {5'd3, 6'd14, 6'd9, 7'd30};
    write_alarm(a);
    run_minute(a, 1'b0, "R2");
    // R6: latched through a mismatching minute
    run_minute(a ^ 24'h1, 1'b0, "R6 hold");
    pulse_clr();
    check("R6 clear", comp_o, 1'b0);
    // R3: mismatch leaves comp at 0
    run_minute(a ^ 24'h80, 1'b0, "R3");
    // R7: clear coincident with set
    run_minute(a, 1'b1, "R7");
    // R6: clear right after set
    pulse_clr();
    check("R6 immediate", comp_o, 1'b0);
    // R4: date ignored
    set_noda(1'b1);
    check("R8 set", noda_o, 1'b1);
    run_minute({5'd7, 6'd2, a[12:0]}, 1'b0, "R4");
    pulse_clr();
    // R5: date compared
    set_noda(1'b0);
    check("R8 clr", noda_o, 1'b0);
    run_minute({5'd7, a[18:0]}, 1'b0, "R5");
    // R8: both commands together
    @(negedge clk); cmd_set_noda = 1'b1; cmd_clr_noda = 1'b1;
    @(negedge clk); cmd_set_noda = 1'b0; cmd_clr_noda = 1'b0; m_noda = 1'b1;
    check("R8 both", noda_o, 1'b1);
    repeat (5) @(negedge clk);
    check("R8 hold", noda_o, 1'b1);
    set_noda(1'b0);
    // R10: stray ticks with matching calendar
    cal_value = a;
    for (int k = 0; k < 300; k++) begin
      tick_en = 1'b1; @(negedge clk); tick_en = 1'b0; @(negedge clk);
    end
    check("R10", comp_o, 1'b0);

    // R9: random alarms, modes and near-miss calendars
    for (int n = 0; n < 40; n++) begin
      a = $urandom();
      write_alarm(a);
      set_noda(1'($urandom_range(0, 1)));
      c = a;
      if ($urandom_range(0, 2) != 0) begin
        int f;
        f = $urandom_range(0, 3);
        case (f)
          0: c[6:0]   = c[6:0]   ^ 7'(1 << $urandom_range(0, 6));
          1: c[12:7]  = c[12:7]  ^ 6'(1 << $urandom_range(0, 5));
          2: c[18:13] = c[18:13] ^ 6'(1 << $urandom_range(0, 5));
          default: c[23:19] = c[23:19] ^ 5'(1 << $urandom_range(0, 4));
        endcase
      end
      pulse_clr();
      run_minute(c, 1'b0, "R9");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule